// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned 32-bit integer by another over many clock cycles and returns both the quotient and the remainder. It uses a double-width divisor register, a double-width partial-remainder register and a quotient shift register. A single 64-bit adder/subtractor serves both the trial subtraction and the add-back.

Each trial step subtracts the current divisor value from the partial remainder. If the difference is non-negative, the step keeps it and shifts a 1 into the quotient. If the difference is negative, the step adds the divisor back in a second cycle and shifts a 0 into the quotient. After every step the divisor moves one place to the right.

A caller presents both operands with a one-cycle start pulse while the block is idle. It then waits for the one-cycle done pulse and reads the results, which hold until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: A synchronous active-low reset, applied at any time, returns the block to idle, with `busy_o` and `done_o` low on the cycle after the reset edge.
- R2: `start_i` is accepted only while `busy_o` is low. The operands are captured on that edge, and `busy_o` is high from the next cycle through the done cycle.
- R3: For a non-zero divisor, `quotient_o` equals the integer quotient of the dividend by the divisor when `done_o` is high.
- R4: For a non-zero divisor, `remainder_o` equals the dividend modulo the divisor when `done_o` is high.
- R5: A zero divisor completes normally and yields a quotient of 32'hFFFFFFFF and a remainder equal to the dividend.
- R6: An operation runs 33 trial steps, for the divisor shifted left by 32 down to 0. A step whose trial difference is non-negative takes one cycle; a negative step takes two. `done_o` rises exactly 33+Z cycles after the accepting edge, where Z is the number of negative steps.
- R7: `done_o` is high for exactly one cycle, and `busy_o` falls on the following cycle.
- R8: A start pulse that arrives while busy is ignored. The running operation keeps its operands, its results and its timing.
- R9: After done, `quotient_o` and `remainder_o` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a division when idle |
| dividend_i | input | 32 | Unsigned dividend, sampled with start |
| divisor_i | input | 32 | Unsigned divisor, sampled with start |
| busy_o | output | 1 | An operation is in progress (including the done cycle) |
| done_o | output | 1 | One-cycle pulse: results are valid |
| quotient_o | output | 32 | Quotient |
| remainder_o | output | 32 | Remainder |

## Verification
The bench computes each operation's latency before issuing it, by walking the 33 trial steps and counting how many would go negative, so `done_o` is expected 33+Z cycles after the accepting edge. On every falling edge it compares `busy_o` and `done_o` with that count, and compares the quotient and remainder in the predicted done cycle. It compares them again in the idle cycles that follow. Some runs hold `start_i` high with different operands throughout the operation, and a reset is applied mid-operation, to show that neither disturbs the expected timing and values.

// File: rtl/div_pkg.sv
// Shared types for the restoring divider.
// Assumes: used by div_ctrl only; no parameters live here.
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for start
        ST_TRY,    // trial subtraction this cycle
        ST_UNDO,   // add divisor back after a negative trial
        ST_FIN     // one-cycle completion
    } div_state_e;
endpackage

// File: rtl/div_addsub.sv
// Shared add/subtract unit for the divider datapath.
// Does: a - b when sub_i is set, a + b otherwise, mod 2**DW.
// Flags neg_o when a subtraction borrows (unsigned a < b).
// Assumes: purely combinational, no state.
module div_addsub #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          neg_o
);
    logic [DW:0] wide;

    // Extended-width add or subtract so the borrow lands in the top bit.
    always_comb begin
        if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
        else       wide = {1'b0, a_i} + {1'b0, b_i};
    end

    assign sum_o = wide[DW-1:0];
    assign neg_o = sub_i & wide[DW];
endmodule

// File: rtl/div_ctrl.sv
// Control state machine for the restoring divider.
// Does: sequences STEPS trial steps, inserting an add-back cycle
// after each negative trial, then pulses done for one cycle.
// Assumes: neg_i is valid in ST_TRY; synchronous active-low reset.
module div_ctrl
    import div_pkg::*;
#(
    parameter int STEPS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic neg_i,
    output logic load_o,
    output logic sub_o,
    output logic rem_we_o,
    output logic step_o,
    output logic qbit_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(STEPS + 1);

    div_state_e    state, state_nx;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(STEPS - 1));

    // Datapath strobes decoded from the current state.
    always_comb begin
        load_o   = (state == ST_IDLE) && start_i;
        sub_o    = (state == ST_TRY);
        rem_we_o = (state == ST_TRY) || (state == ST_UNDO);
        step_o   = ((state == ST_TRY) && !neg_i) || (state == ST_UNDO);
        qbit_o   = (state == ST_TRY);
        busy_o   = (state != ST_IDLE);
        done_o   = (state == ST_FIN);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_i) state_nx = ST_TRY;
            ST_TRY:  if (neg_i)   state_nx = ST_UNDO;
                     else         state_nx = last ? ST_FIN : ST_TRY;
            ST_UNDO: state_nx = last ? ST_FIN : ST_TRY;
            ST_FIN:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and step-counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (load_o)      cnt <= '0;
            else if (step_o) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/div_datapath.sv
// Register datapath of the restoring divider.
// Does: holds a double-width divisor that shifts right each step, a
// double-width partial remainder, and a quotient that shifts left.
// Assumes: strobes come from div_ctrl; step and rem_we may coincide.
module div_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         sub_i,
    input  logic         rem_we_i,
    input  logic         step_i,
    input  logic         qbit_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         neg_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvs_q;
    logic [DW-1:0] rem_q;
    logic [W-1:0]  quo_q;
    logic [DW-1:0] sum;

    div_addsub #(.DW(DW)) u_addsub (
        .a_i   (rem_q),
        .b_i   (dvs_q),
        .sub_i (sub_i),
        .sum_o (sum),
        .neg_o (neg_o)
    );

    // Load operands, then update remainder, quotient and divisor per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvs_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            dvs_q <= {divisor_i, {W{1'b0}}};
            rem_q <= {{W{1'b0}}, dividend_i};
            quo_q <= '0;
        end else begin
            if (rem_we_i) rem_q <= sum;
            if (step_i) begin
                quo_q <= {quo_q[W-2:0], qbit_i};
                dvs_q <= dvs_q >> 1;
            end
        end
    end

    assign quotient_o  = quo_q;
    assign remainder_o = rem_q[W-1:0];
endmodule

// File: rtl/restoring_divider.sv
// Top of the unsigned restoring sequential divider.
// Does: connects the controller to the datapath; start/done handshake.
// Assumes: start_i is honoured only while busy_o is low.
module restoring_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o
);
    localparam int STEPS = W + 1;

    logic load, sub, rem_we, step, qbit, neg;

    div_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .neg_i    (neg),
        .load_o   (load),
        .sub_o    (sub),
        .rem_we_o (rem_we),
        .step_o   (step),
        .qbit_o   (qbit),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    div_datapath #(.W(W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .sub_i       (sub),
        .rem_we_i    (rem_we),
        .step_i      (step),
        .qbit_i      (qbit),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .neg_o       (neg),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );
endmodule

// File: rtl/restoring_divider_chk.sv
// Property checker for restoring_divider, attached by bind.
// Does: captures accepted operands and checks results, pulse shape,
// busy behaviour and a latency bound.
// Assumes: observes the top-level ports only.
module restoring_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o
);
    localparam int LIM = 2 * (W + 1) + 1;
    localparam int LW  = $clog2(LIM + 2);

    logic [W-1:0]  a_cap, b_cap;
    logic [LW-1:0] run_cnt;
    logic [2*W-1:0] recon;

    // Capture operands on an accepted start; count busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cap   <= '0;
            b_cap   <= '0;
            run_cnt <= '0;
        end else begin
            if (start_i && !busy_o) begin
                a_cap <= dividend_i;
                b_cap <= divisor_i;
            end
            if (busy_o) run_cnt <= run_cnt + 1'b1;
            else        run_cnt <= '0;
        end
    end

    assign recon = ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, b_cap})
                 + {{W{1'b0}}, remainder_o};

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    quot_recon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && b_cap != '0) |-> (recon == {{W{1'b0}}, a_cap}));

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && b_cap != '0) |-> (remainder_o < b_cap));

    // R5
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && b_cap == '0) |-> (quotient_o == '1 && remainder_o == a_cap));

    // R6
    latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_cnt <= LW'(LIM)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && $past(!busy_o || done_o))
            |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
);

// File: tb/restoring_divider_tb_top.sv
module restoring_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] quotient_o, remainder_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    restoring_divider #(.W(32)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural expectation: quotient, remainder and negative-step count.
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] q, output logic [31:0] r,
                         output int z);
        logic [63:0] acc;
        acc = {32'b0, a};
        z = 0;
        for (int i = 32; i >= 0; i--) begin
            logic [63:0] d;
            d = {32'b0, b} << i;
            if (acc >= d) acc = acc - d;
            else z++;
        end
        if (b == 0) begin
            q = 32'hFFFF_FFFF;
            r = a;
        end else begin
            q = a / b;
            r = a % b;
        end
    endtask

    // Issue one division and compare the outputs on every cycle.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input bit noisy);
        logic [31:0] eq, er;
        int z, lat;
        model(a, b, eq, er, z);
        lat = 33 + z;
        @(negedge clk);
        start_i = 1'b1;
        dividend_i = a;
        divisor_i = b;
        for (int n = 0; n <= lat; n++) begin
            @(negedge clk);
            if (noisy && n < lat) begin
                start_i = 1'b1;
                dividend_i = ~a;
                divisor_i = b + 32'd3;
            end else begin
                start_i = 1'b0;
            end
            check(busy_o == 1'b1, "R2 busy", busy_o, 1);
            check(done_o == (n == lat), noisy ? "R8 done timing" : "R6 done timing",
                  done_o, (n == lat));
            if (n == lat) begin
                check(quotient_o == eq, b == 0 ? "R5 quotient" : "R3 quotient",
                      quotient_o, eq);
                check(remainder_o == er, b == 0 ? "R5 remainder" : "R4 remainder",
                      remainder_o, er);
            end
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!busy_o && !done_o, "R7 pulse end", {busy_o, done_o}, 0);
            check(quotient_o == eq && remainder_o == er, "R9 hold",
                  {quotient_o, remainder_o}, {eq, er});
        end
    endtask

    initial begin
        logic [31:0] seed;
        seed = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R1 reset", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 idle", {busy_o, done_o}, 0);

        run_op(32'd100, 32'd7, 1'b0);
        run_op(32'hFFFF_FFFF, 32'd1, 1'b0);
        run_op(32'd5, 32'd0, 1'b0);
        run_op(32'd0, 32'd3, 1'b0);
        run_op(32'd3, 32'd10, 1'b0);
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
        run_op(32'd12345678, 32'h0001_0000, 1'b0);
        run_op(32'hDEAD_BEEF, 32'd0, 1'b0);
        run_op(32'd1000, 32'd33, 1'b1);
        run_op(32'hCAFE_0001, 32'd17, 1'b1);

        // R1: reset in the middle of an operation.
        @(negedge clk);
        start_i = 1'b1; dividend_i = 32'd999; divisor_i = 32'd4;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 mid reset", {busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o, "R1 stays idle", busy_o, 0);

        for (int t = 0; t < 24; t++) begin
            logic [31:0] a, b;
            seed = seed * 32'd1664525 + 32'd1013904223;
            a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223;
            b = seed >> (seed[4:0]);
            run_op(a, b, t[2]);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule